// File: doc/BRIEF.md
# Double Data Rate Output Serializer

This block drives a row of output pins at twice the word rate. Each rising edge of the primary clock `clk_a` accepts one pair of bits per lane from the fabric. The pin then shows the first bit while `clk_a` is high and the second bit while `clk_a` is low. A second clock, `clk_b`, is normally the exact complement of `clk_a`.

The first bit goes into a register on the rising edge of `clk_a`. The second bit is also taken in the `clk_a` domain, into a hold register. It is then registered again on the next rising edge of `clk_b`, half a period later. A per-lane multiplexer, steered by the level of `clk_a`, selects which of the two output registers reaches the pin.

The interface uses plain enable and reset pins and has no handshake. A low `ce` holds every register, so the pin repeats the last pair. A synchronous `rst` clears the registers so the pin drives 0. The lane count is a parameter.

Top module: `ddr_out_serializer`

## Requirements
- R1: At a rising `clk_a` edge with `rst` low and `ce` high, `d_first` is registered. It appears on `pin` for the whole following high phase of `clk_a`.
- R2: At the same edge, `d_second` goes into a hold register in the `clk_a` domain. It is registered again at the next rising `clk_b` edge and appears on `pin` for the following low phase of `clk_a`. Each pair therefore leaves first bit, then second bit.
- R3: `pin` shows the first-bit register while `clk_a` is 1 and the second-bit register while `clk_a` is 0.
- R4: At a rising `clk_a` edge with `rst` low and `ce` low, all registers keep their values. `pin` repeats the last accepted pair in every later period until `ce` returns high.
- R5: At a rising `clk_a` edge with `rst` high, the first-bit and hold registers clear to 0 whatever `ce` is. The second-bit register clears at the next rising `clk_b` edge, so `pin` is 0 in both halves of that period.
- R6: Lanes are independent: bit i of `pin` depends only on bit i of `d_first` and `d_second`. Every combination of lane values is carried unchanged.
- R7: After `rst` falls, the first edge with `rst` low and `ce` high captures a pair. That pair appears in the same period, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Primary clock; data and control are sampled on its rising edge |
| clk_b | input | 1 | Secondary clock, normally the complement of `clk_a` |
| rst | input | 1 | Synchronous reset, active high, sampled by both clocks |
| ce | input | 1 | Clock enable for accepting a new pair |
| d_first | input | LANES | Bit sent during the high phase of `clk_a` |
| d_second | input | LANES | Bit sent during the low phase of `clk_a` |
| pin | output | LANES | Serialized output |

## Verification
The hardest case to reach is a reset at an edge where `ce` is low. Here the second-bit register must clear half a period after the other registers, even though nothing is being accepted. The bench first streams pairs so that every register holds ones. It then stalls with `ce` low and raises `rst` while the stall lasts. After that it checks both half-periods of the following cycles and the first pair accepted once reset ends. An exhaustive sweep of all lane patterns, in every pair of consecutive words, covers lane independence and each transition.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int unsigned DEF_LANES = 2;
endpackage

// File: rtl/ddr_rise_stage.sv
module ddr_rise_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk_a,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d_first,
  input  logic [W-1:0] d_second,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] mid_q
);
  // The second bit is parked here in the primary domain; the fall stage
  // retimes it half a period later.
  always_ff @(posedge clk_a) begin
    if (rst) begin
      rise_q <= '0;
      mid_q  <= '0;
    end else if (ce) begin
      rise_q <= d_first;
      mid_q  <= d_second;
    end
  end
endmodule

// File: rtl/ddr_fall_stage.sv
module ddr_fall_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk_b,
  input  logic         rst,
  input  logic [W-1:0] mid_q,
  output logic [W-1:0] fall_q
);
  // Half-cycle crossing: mid_q changes only at rising clk_a, so it is
  // stable at every rising clk_b edge when the clocks are complements.
  always_ff @(posedge clk_b) begin
    if (rst) fall_q <= '0;
    else     fall_q <= mid_q;
  end
endmodule

// File: rtl/ddr_out_mux.sv
module ddr_out_mux
  import ddr_ser_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         phase,
  input  logic [W-1:0] rise_q,
  input  logic [W-1:0] fall_q,
  output logic [W-1:0] pin
);
  phase_e ph;
  assign ph = phase_e'(phase);

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign pin[i] = (ph == PH_HIGH) ? rise_q[i] : fall_q[i];
  end
endmodule

// File: rtl/ddr_out_serializer.sv
module ddr_out_serializer
  import ddr_ser_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst,
  input  logic             ce,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_second,
  output logic [LANES-1:0] pin
);
  logic [LANES-1:0] rise_q;
  logic [LANES-1:0] mid_q;
  logic [LANES-1:0] fall_q;

  ddr_rise_stage #(.W(LANES)) u_rise (
    .clk_a    (clk_a),
    .rst      (rst),
    .ce       (ce),
    .d_first  (d_first),
    .d_second (d_second),
    .rise_q   (rise_q),
    .mid_q    (mid_q)
  );

  ddr_fall_stage #(.W(LANES)) u_fall (
    .clk_b  (clk_b),
    .rst    (rst),
    .mid_q  (mid_q),
    .fall_q (fall_q)
  );

  ddr_out_mux #(.W(LANES)) u_mux (
    .phase  (clk_a),
    .rise_q (rise_q),
    .fall_q (fall_q),
    .pin    (pin)
  );
endmodule

// File: rtl/ddr_out_serializer_chk.sv
module ddr_out_serializer_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst,
  input logic             ce,
  input logic [LANES-1:0] d_first,
  input logic [LANES-1:0] pin,
  input logic [LANES-1:0] rise_q,
  input logic [LANES-1:0] mid_q,
  input logic [LANES-1:0] fall_q
);
  logic rst_seen_a = 1'b0;
  logic rst_seen_b = 1'b0;

  always @(posedge clk_a) rst_seen_a <= rst;
  always @(posedge clk_b) rst_seen_b <= rst;

  AST_FIRST_CAPTURE: assert property (@(posedge clk_a) disable iff (rst)
    ce |=> (rise_q == $past(d_first)));  // R1

  AST_SECOND_RETIME: assert property (@(posedge clk_b) disable iff (rst)
    !rst |=> (fall_q == $past(mid_q)));  // R2

  AST_PIN_HIGH_PHASE: assert property (@(negedge clk_a) disable iff (rst)
    pin == rise_q);  // R3

  AST_PIN_LOW_PHASE: assert property (@(negedge clk_b) disable iff (rst)
    pin == fall_q);  // R3

  AST_STALL_HOLDS: assert property (@(posedge clk_a) disable iff (rst)
    !ce |=> ($stable(rise_q) && $stable(mid_q)));  // R4

  always @(negedge clk_a) begin
    if (rst_seen_a) begin
      AST_RESET_RISE: assert (rise_q == '0 && mid_q == '0);  // R5
    end
  end

  always @(negedge clk_b) begin
    if (rst_seen_b) begin
      AST_RESET_FALL: assert (fall_q == '0);  // R5
    end
  end
endmodule

bind ddr_out_serializer ddr_out_serializer_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/ddr_out_serializer_bench.sv
`timescale 1ns/1ps
module ddr_out_serializer_bench;
  localparam int unsigned LANES = 2;
  localparam int unsigned NPAT  = 1 << (2 * LANES);

  logic             clk_a = 1'b0;
  logic             clk_b;
  logic             rst = 1'b1;
  logic             ce = 1'b0;
  logic [LANES-1:0] d_first = '0;
  logic [LANES-1:0] d_second = '0;
  logic [LANES-1:0] pin;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  // bench model of the two output registers
  logic [LANES-1:0] m_first = '0;
  logic [LANES-1:0] m_second = '0;

  always #2.5 clk_a = ~clk_a;
  assign clk_b = ~clk_a;

  ddr_out_serializer #(.LANES(LANES)) u_ddr_out_serializer (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst      (rst),
    .ce       (ce),
    .d_first  (d_first),
    .d_second (d_second),
    .pin      (pin)
  );

  task automatic check(input string tag, input logic [LANES-1:0] got,
                       input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pin=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive one period's inputs, then check both halves of that period.
  task automatic step(input logic [LANES-1:0] f, input logic [LANES-1:0] s,
                      input logic nce, input logic nrst,
                      input string thi, input string tlo);
    d_first  = f;
    d_second = s;
    ce       = nce;
    rst      = nrst;
    if (nrst) begin
      m_first  = '0;
      m_second = '0;
    end else if (nce) begin
      m_first  = f;
      m_second = s;
    end
    @(posedge clk_a);
    #1.25 check(thi, pin, m_first);
    #2.5  check(tlo, pin, m_second);
  endtask

  initial begin
    #1;
    // reset state, with data present on the inputs
    step('1, '1, 1'b1, 1'b1, "R5 reset high", "R5 reset low");
    step('1, '1, 1'b0, 1'b1, "R5 reset high", "R5 reset low");
    // first pair after reset appears at once
    step(2'b10, 2'b01, 1'b1, 1'b0, "R7 first hi", "R7 first lo");

    // exhaustive sweep over every consecutive word pair
    for (int a = 0; a < NPAT; a++) begin
      for (int b = 0; b < NPAT; b++) begin
        step(a[LANES-1:0], a[2*LANES-1:LANES], 1'b1, 1'b0, "R1 R6 hi", "R2 R6 lo");
        step(b[LANES-1:0], b[2*LANES-1:LANES], 1'b1, 1'b0, "R1 R3 hi", "R2 R3 lo");
      end
    end

    // stalls: changing inputs while ce is low must not reach the pin
    for (int i = 0; i < 48; i++) begin
      logic [2*LANES-1:0] v;
      v = (2*LANES)'(i * 7 + 3);
      step(v[LANES-1:0], v[2*LANES-1:LANES], (i % 3) != 0, 1'b0,
           "R4 stall hi", "R4 stall lo");
    end

    // reset during a stall, after loading ones
    step('1, '1, 1'b1, 1'b0, "R1 load hi", "R2 load lo");
    step('0, '0, 1'b0, 1'b0, "R4 hold hi", "R4 hold lo");
    step('0, '0, 1'b0, 1'b1, "R5 stall rst hi", "R5 stall rst lo");
    step('1, '1, 1'b0, 1'b0, "R5 after rst hi", "R5 after rst lo");
    step(2'b01, 2'b11, 1'b1, 1'b0, "R7 resume hi", "R7 resume lo");
    step(2'b01, 2'b11, 1'b1, 1'b1, "R5 mid rst hi", "R5 mid rst lo");
    step(2'b11, 2'b10, 1'b1, 1'b0, "R7 restart hi", "R7 restart lo");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule